// File: doc/BRIEF.md
# Reconfigurable Threshold Gate Neuron

This block is a single artificial neuron with two binary inputs. It forms a weighted sum and then applies a saturating activation. That activation is the rising branch of a ferroelectric polarisation loop: a hyperbolic tangent shifted right by a coercive offset, stretched by a width set by the remanent-to-saturation ratio, and normalised so that it saturates at ±1. The sum always includes a bias term whose input is fixed at +1. Loading a different set of three signed weights therefore changes which Boolean function the neuron computes, with no change to the hardware. The stock weight sets give AND, NAND, OR and NOR. XOR is not linearly separable, so no weight set gives it on one unit.

Operands enter on a valid/ready stream: one beat carries two data bits and three weights. The result leaves on a second valid/ready stream: one beat carries the signed Q3.12 activation and a logic bit. The logic bit is 1 when the activation is at least one half. A beat is accepted on a clock edge where both `in_valid` and `in_ready` are high. Its result is presented from the next cycle onward. The result stays on the outputs, unchanged, until the edge where both `out_valid` and `out_ready` are high. While a result is held, `in_ready` is low. In the same cycle that `out_ready` takes the held result, the block can accept a new beat, so it sustains one result per cycle. The block keeps no hysteresis state from one evaluation to the next.

Top module: `threshold_neuron`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: The neuron sum is `w_bias + (in_x1 ? w_x1 : 0) + (in_x2 ? w_x2 : 0)`. All three weights are signed Q3.12, so 4096 stands for 1.0. The bias input is always +1.
- R3: `out_act` equals round(4096 · tanh((v − Ec)/(2δ))) to within ±2 LSB. Here v is the sum after the clamp of R5, rounded down to a multiple of 128 (1/32). The output never leaves ±4096.
- R4: With default parameters, Ec = 1311/4096 and 2δ = 2·Ec / ln((1+r)/(1−r)), where r = 15/23. The transition width therefore depends only on the ratio r.
- R5: Sums above 16383 act as 16383 and sums below −16384 act as −16384, so the activation curve has 256 steps of 128 LSB. Very large positive sums give +4096 and very large negative sums give −4096.
- R6: `out_bit` is 1 exactly when `out_act` ≥ 2048 (0.5).
- R7: A beat accepted on edge k has `out_valid` = 1 after edge k. With `out_ready` = 1 and no new beat, `out_valid` returns to 0 after edge k+1.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and `out_act` and `out_bit` hold steady even when `in_valid` is high.
- R9: The weight sets (bias, x1, x2) AND = (−1540, 2617, 2617), NAND = (6435, −2662, −2662), OR = (1036, 2904, 2904) and NOR = (3748, −2740, −2740) give the named truth table on `out_bit`.
- R10: The same operands always give the same `out_act`, whatever beats came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_x1 | input | 1 | First data bit |
| in_x2 | input | 1 | Second data bit |
| w_bias | input | 16 | Signed Q3.12 weight on the constant +1 input |
| w_x1 | input | 16 | Signed Q3.12 weight on the first data bit |
| w_x2 | input | 16 | Signed Q3.12 weight on the second data bit |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_act | output | 16 | Signed Q3.12 activation, normalised to ±4096 |
| out_bit | output | 1 | Thresholded logic value |

## Verification
Any wrong internal state shows up at the ports on the very next result beat. A wrong bin index, clamp or table entry moves `out_act` away from the tanh model at that sum. A sweep of the bias weight across the whole clamp window therefore exposes any bad step within one cycle of the beat that hits it. A fire threshold that does not match the table makes `out_bit` disagree with `out_act` on the same beat. A stuck or early valid flag breaks the one-cycle latency or the stall-hold behaviour in the cycle it happens. Any leftover state from an earlier beat would make the activation depend on that history.

// File: rtl/tn_pkg.sv
package tn_pkg;

  localparam int     QB  = 30;
  localparam longint ONE = 64'sd1 <<< QB;

  // ln((1+r)/(1-r)) with r = pr/ps, as 2*atanh(r), Q30
  function automatic longint log_ratio_q30(input int pr, input int ps);
    longint r, r2, pw, acc;
    r   = (longint'(pr) <<< QB) / longint'(ps);
    r2  = (r * r) >>> QB;
    pw  = r;
    acc = 0;
    for (int k = 0; k < 48; k++) begin
      acc += pw / longint'(2 * k + 1);
      pw   = (pw * r2) >>> QB;
    end
    return 2 * acc;
  endfunction

  // e^(-x) for x >= 0, Q30 in and out
  function automatic longint exp_neg_q30(input longint x);
    longint y, term, acc;
    if (x > (longint'(40) <<< QB)) return 0;
    y    = x >>> 6;
    term = ONE;
    acc  = ONE;
    for (int n = 1; n <= 12; n++) begin
      term = -((term * y) >>> QB) / longint'(n);
      acc += term;
    end
    for (int s = 0; s < 6; s++) acc = (acc * acc) >>> QB;
    return acc;
  endfunction

  // tanh(u) for u >= 0, Q30
  function automatic longint tanh_pos_q30(input longint u);
    longint e;
    e = exp_neg_q30(2 * u);
    return ((ONE - e) <<< QB) / (ONE + e);
  endfunction

  // activation table entry i, in Q(frac)
  function automatic longint lut_entry(input int i, input int lut_bits, input int shift,
                                       input int frac, input int ec_q, input longint lr_q30);
    longint v, d, mag, u, t;
    v   = longint'(i - (1 << (lut_bits - 1))) <<< shift;
    d   = v - longint'(ec_q);
    mag = (d < 0) ? -d : d;
    u   = (mag * lr_q30) / (2 * longint'(ec_q));
    t   = tanh_pos_q30(u);
    mag = (t + (ONE >>> (frac + 1))) >>> (QB - frac);
    return (d < 0) ? -mag : mag;
  endfunction

  // first table index whose entry reaches one half
  function automatic int fire_index(input int lut_bits, input int shift, input int frac,
                                    input int ec_q, input longint lr_q30);
    for (int i = 0; i < (1 << lut_bits); i++)
      if (lut_entry(i, lut_bits, shift, frac, ec_q, lr_q30) >= (longint'(1) <<< (frac - 1)))
        return i;
    return 1 << lut_bits;
  endfunction

endpackage

// File: rtl/tn_sum.sv
module tn_sum #(
  parameter int DW       = 16,
  parameter int FRAC     = 12,
  parameter int LUT_BITS = 8,
  parameter int CLAMP_IB = 2
) (
  input  logic                   x1,
  input  logic                   x2,
  input  logic signed [DW-1:0]   w_bias,
  input  logic signed [DW-1:0]   w_x1,
  input  logic signed [DW-1:0]   w_x2,
  output logic [LUT_BITS-1:0]    idx
);
  localparam int SW       = DW + 2;
  localparam int SHIFT    = FRAC + CLAMP_IB + 1 - LUT_BITS;
  localparam int HI_VAL   = (1 << (FRAC + CLAMP_IB)) - 1;
  localparam int LO_VAL   = -(1 << (FRAC + CLAMP_IB));
  localparam int MID_IDX  = 1 << (LUT_BITS - 1);

  logic                 xv   [2];
  logic signed [DW-1:0] wv   [2];
  logic signed [SW-1:0] term [3];
  logic signed [SW-1:0] sum, clamped, binned;

  assign xv[0] = x1;
  assign xv[1] = x2;
  assign wv[0] = w_x1;
  assign wv[1] = w_x2;

  // bias input is a constant one
  assign term[0] = SW'(w_bias);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_in
      assign term[g+1] = xv[g] ? SW'(wv[g]) : '0;
    end
  endgenerate

  assign sum = term[0] + term[1] + term[2];

  always_comb begin
    if (sum > SW'(HI_VAL))      clamped = SW'(HI_VAL);
    else if (sum < SW'(LO_VAL)) clamped = SW'(LO_VAL);
    else                        clamped = sum;
  end

  assign binned = (clamped >>> SHIFT) + SW'(MID_IDX);
  assign idx    = LUT_BITS'(binned);
endmodule

// File: rtl/tn_act_rom.sv
module tn_act_rom #(
  parameter int DW       = 16,
  parameter int FRAC     = 12,
  parameter int LUT_BITS = 8,
  parameter int CLAMP_IB = 2,
  parameter int EC_Q     = 1311,
  parameter int PR       = 15,
  parameter int PS       = 23
) (
  input  logic [LUT_BITS-1:0]  idx,
  output logic signed [DW-1:0] act,
  output logic                 fire
);
  localparam int     DEPTH = 1 << LUT_BITS;
  localparam int     SHIFT = FRAC + CLAMP_IB + 1 - LUT_BITS;
  localparam longint LR    = tn_pkg::log_ratio_q30(PR, PS);
  localparam int     THR   = tn_pkg::fire_index(LUT_BITS, SHIFT, FRAC, EC_Q, LR);

  logic signed [DW-1:0] rom [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      localparam longint ENT = tn_pkg::lut_entry(i, LUT_BITS, SHIFT, FRAC, EC_Q, LR);
      assign rom[i] = DW'(ENT);
    end
  endgenerate

  assign act  = rom[idx];
  // curve is monotone, so the logic level is an index compare
  assign fire = ({1'b0, idx} >= (LUT_BITS+1)'(THR));
endmodule

// File: rtl/tn_out_reg.sv
module tn_out_reg #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 drain,
  input  logic signed [DW-1:0] d_act,
  input  logic                 d_bit,
  output logic                 q_valid,
  output logic signed [DW-1:0] q_act,
  output logic                 q_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_act   <= '0;
      q_bit   <= 1'b0;
    end else if (take) begin
      q_valid <= 1'b1;
      q_act   <= d_act;
      q_bit   <= d_bit;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/threshold_neuron.sv
module threshold_neuron #(
  parameter int DW       = 16,
  parameter int FRAC     = 12,
  parameter int LUT_BITS = 8,
  parameter int CLAMP_IB = 2,
  parameter int EC_Q     = 1311,
  parameter int PR       = 15,
  parameter int PS       = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_x1,
  input  logic                 in_x2,
  input  logic signed [DW-1:0] w_bias,
  input  logic signed [DW-1:0] w_x1,
  input  logic signed [DW-1:0] w_x2,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_act,
  output logic                 out_bit
);
  logic [LUT_BITS-1:0]  idx;
  logic signed [DW-1:0] act_c;
  logic                 fire_c;
  logic                 take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  tn_sum #(.DW(DW), .FRAC(FRAC), .LUT_BITS(LUT_BITS), .CLAMP_IB(CLAMP_IB)) u_sum (
    .x1(in_x1), .x2(in_x2), .w_bias(w_bias), .w_x1(w_x1), .w_x2(w_x2), .idx(idx)
  );

  tn_act_rom #(.DW(DW), .FRAC(FRAC), .LUT_BITS(LUT_BITS), .CLAMP_IB(CLAMP_IB),
               .EC_Q(EC_Q), .PR(PR), .PS(PS)) u_rom (
    .idx(idx), .act(act_c), .fire(fire_c)
  );

  tn_out_reg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .take(take), .drain(out_ready),
    .d_act(act_c), .d_bit(fire_c),
    .q_valid(out_valid), .q_act(out_act), .q_bit(out_bit)
  );
endmodule

// File: rtl/tn_checker.sv
module tn_checker #(
  parameter int DW   = 16,
  parameter int FRAC = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] out_act,
  input logic                 out_bit
);
  localparam logic signed [DW-1:0] FULL = DW'(1 << FRAC);
  localparam logic signed [DW-1:0] HALF = DW'(1 << (FRAC - 1));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> $past(in_valid && in_ready));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_act) && $stable(out_bit)));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_bit_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bit == (out_act >= HALF)));

  assert_act_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_act <= FULL) && (out_act >= -FULL)));
endmodule

bind threshold_neuron tn_checker #(.DW(DW), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act), .out_bit(out_bit)
);

// File: tb/sim_threshold_neuron.sv
module sim_threshold_neuron;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_x1 = 1'b0, in_x2 = 1'b0;
  logic signed [15:0] w_bias = '0, w_x1 = '0, w_x2 = '0;
  logic out_valid, out_ready = 1'b1, out_bit;
  logic signed [15:0] out_act;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  threshold_neuron u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x1(in_x1), .in_x2(in_x2), .w_bias(w_bias), .w_x1(w_x1), .w_x2(w_x2),
    .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act), .out_bit(out_bit)
  );

  function automatic int model_act(input int s);
    int c, bin;
    real ec, r, twod, t;
    c    = (s > 16383) ? 16383 : ((s < -16384) ? -16384 : s);
    bin  = (c >>> 7) <<< 7;
    ec   = 1311.0 / 4096.0;
    r    = 15.0 / 23.0;
    twod = 2.0 * ec / $ln((1.0 + r) / (1.0 - r));
    t    = 4096.0 * $tanh(((bin / 4096.0) - ec) / twod);
    return (t >= 0.0) ? $rtoi(t + 0.5) : -$rtoi(-t + 0.5);
  endfunction

  task automatic check(input string req, input bit ok, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic check_act(input string req, input int exp);
    int d;
    d = int'(out_act) - exp;
    check(req, (d <= 2) && (d >= -2), int'(out_act), exp);
  endtask

  task automatic send(input bit a, input bit b, input int w0, input int w1, input int w2);
    @(negedge clk);
    in_x1 = a; in_x2 = b;
    w_bias = 16'(w0); w_x1 = 16'(w1); w_x2 = 16'(w2);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid in reset", out_valid == 1'b0, int'(out_valid), 0);
    check("R1 ready in reset", in_ready == 1'b1, int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", out_valid == 1'b0, int'(out_valid), 0);
  endtask

  task automatic t_gate(input string name, input int w0, input int w1, input int w2,
                        input bit [3:0] truth);
    for (int p = 0; p < 4; p++) begin
      bit a, b;
      int s, e;
      a = p[1]; b = p[0];
      s = w0 + (a ? w1 : 0) + (b ? w2 : 0);
      e = model_act(s);
      send(a, b, w0, w1, w2);
      check({"R9 ", name}, out_bit == truth[p], int'(out_bit), int'(truth[p]));
      check_act("R2 weighted sum with bias", e);
    end
  endtask

  task automatic t_sweep;
    for (int w = -18000; w <= 18000; w += 500) begin
      int e;
      e = model_act(w);
      send(1'b0, 1'b0, w, 0, 0);
      check_act("R3 R4 curve", e);
      if (e > 2050 || e < 2046)
        check("R6 level", out_bit == (e >= 2048), int'(out_bit), int'(e >= 2048));
    end
  endtask

  task automatic t_clamp;
    send(1'b1, 1'b1, 32767, 32767, 32767);
    check_act("R5 top clamp", model_act(16383));
    check("R5 top saturates", out_act == 16'sd4096, int'(out_act), 4096);
    send(1'b1, 1'b1, -32768, -32768, -32768);
    check_act("R5 bottom clamp", model_act(-16384));
    check("R5 bottom saturates", out_act == -16'sd4096, int'(out_act), -4096);
    send(1'b1, 1'b0, 16383, 1, 0);
    check_act("R5 just over top", model_act(16383));
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_x1 = 1'b1; in_x2 = 1'b1;
    w_bias = 16'sd1036; w_x1 = 16'sd2904; w_x2 = 16'sd2904;
    in_valid = 1'b1;
    check("R7 not early", out_valid == 1'b0, int'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 one cycle", out_valid == 1'b1, int'(out_valid), 1);
    @(negedge clk);
    check("R7 drops", out_valid == 1'b0, int'(out_valid), 0);
  endtask

  task automatic t_backpressure;
    int ea, eb;
    ea = model_act(6000);
    eb = model_act(-3000);
    out_ready = 1'b0;
    send(1'b0, 1'b0, 6000, 0, 0);
    check("R8 held valid", out_valid == 1'b1, int'(out_valid), 1);
    check("R8 not ready", in_ready == 1'b0, int'(in_ready), 0);
    in_x1 = 1'b0; in_x2 = 1'b0; w_bias = -16'sd3000;
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_act("R8 value held", ea);
    check("R8 still blocked", in_ready == 1'b0, int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next beat", out_valid == 1'b1, int'(out_valid), 1);
    check_act("R8 next value", eb);
    @(negedge clk);
  endtask

  task automatic t_history;
    int first;
    send(1'b1, 1'b1, -1540, 2617, 2617);
    first = int'(out_act);
    send(1'b0, 1'b0, 6435, -2662, -2662);
    send(1'b1, 1'b1, -32768, -32768, -32768);
    send(1'b1, 1'b1, -1540, 2617, 2617);
    check("R10 no memory", int'(out_act) == first, int'(out_act), first);
    send(1'b1, 1'b1, 32767, 32767, 32767);
    send(1'b1, 1'b1, -1540, 2617, 2617);
    check("R10 no memory high", int'(out_act) == first, int'(out_act), first);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_gate("AND",  -1540,  2617,  2617, 4'b1000);
    t_gate("NAND",  6435, -2662, -2662, 4'b0111);
    t_gate("OR",    1036,  2904,  2904, 4'b1110);
    t_gate("NOR",   3748, -2740, -2740, 4'b0001);
    t_sweep();
    t_clamp();
    t_latency();
    t_backpressure();
    t_history();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule